// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is a configuration port with three lines: a serial clock, a serial data line and an active-low enable. While enable is held low, a host clocks in one 16-bit word with the most significant bit first. When enable goes high again, the word is split into two parts. The low two bits select one of four 14-bit registers. The upper fourteen bits are written into that register.

The serial lines are not used as clocks. They pass through a two-flop synchronizer into the fast system clock domain, and their edges are detected there. A frame counts only if exactly sixteen serial clock edges arrived while enable was low; any other count makes the frame void. The four registers are presented as parallel fields for a fractional-N synthesizer and its surroundings:

- the 28-bit fraction, as two halves;
- the integer divide value;
- the reference divide code;
- the charge-pump current and bleed codes;
- the control bits and the test bits.

Only a synchronous reset returns the registers to their defaults. Writing the power-down bit does not clear them.

Top module: `cfg_serial_port`

## Requirements
- R1: After reset the registers hold these values: fraction upper half 8192, fraction lower half 0, integer divide 177, reference code 0, charge-pump current code 3, bleed code 0, test field 0. The control field is 15, so cp_double_o, buf_en_o and tx_en_o are 1, and pwr_up_o and int_mode_o are 0.
- R2: A frame is 16 bits sampled on rising serial clock edges while ser_en_n_i is low, most significant bit first. Word bits 1..0 are the address and bits 15..2 are the payload. The payload is written when ser_en_n_i rises.
- R3: Address 00 writes the upper fraction half (frac_o[27:14]) and address 01 writes the lower half (frac_o[13:0]).
- R4: For address 10, payload bits 7..0 are the integer divide value, 9..8 the bleed code, 11..10 the charge-pump current code and 13..12 the reference code.
- R5: For address 11, payload bits 5..0 form the control field: bit 0 doubles the charge-pump current, bit 1 is unused, bit 2 enables the buffer, bit 3 enables transmit, bit 4 powers up, and bit 5 selects integer mode. Payload bits 11..6 are the test field and bits 13..12 are spare.
- R6: A frame in which the number of serial clock rises before ser_en_n_i rises is not exactly 16 (for example 15 or 17) changes no register.
- R7: Serial clock edges while ser_en_n_i is high shift nothing and do not disturb the following frame.
- R8: A write changes only the addressed register; the other three keep their values.
- R9: Register contents survive the power-down bit being cleared or set; only rst restores the defaults.
- R10: No output changes while a frame is still open, even after all 16 bits have been clocked in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk_i | input | 1 | Serial clock, asynchronous |
| ser_dat_i | input | 1 | Serial data, MSB first |
| ser_en_n_i | input | 1 | Active-low frame enable; rising edge commits |
| frac_hi_o | output | 14 | Upper fraction half |
| frac_lo_o | output | 14 | Lower fraction half |
| frac_o | output | 28 | Full fraction value |
| int_div_o | output | 8 | Integer divide value |
| ref_div_o | output | 2 | Reference divide code |
| cp_cur_o | output | 2 | Charge-pump current code |
| cp_bleed_o | output | 2 | Charge-pump bleed code |
| cp_double_o | output | 1 | Charge-pump current doubler |
| buf_en_o | output | 1 | Buffer enable |
| tx_en_o | output | 1 | Transmit enable |
| pwr_up_o | output | 1 | Power-up bit (0 means powered down) |
| int_mode_o | output | 1 | Integer mode |
| test_o | output | 6 | Test field |

## Verification
The bench sends frames of 15 and 17 bits. A design that commits on any count, or that keeps the last sixteen bits shifted in, would write a register that should stay unchanged. It toggles the serial clock while enable is high, which catches a design that shifts there and so misaligns the next frame. It also samples the outputs after all sixteen bits have arrived but before enable rises, which catches a design that commits on the bit count. The power-down bit is written both ways to catch a design that clears its registers on software power-down, and the field positions of every address are compared against independent expected values.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;
  localparam int WORD_W   = 16;
  localparam int ADDR_W   = 2;
  localparam int PAY_W    = WORD_W - ADDR_W;
  localparam int NUM_REGS = 1 << ADDR_W;
  localparam int SYNC_STG = 2;

  // field widths of the divider word
  localparam int INT_W   = 8;
  localparam int CODE_W  = 2;
  localparam int CTRL_W  = 6;
  localparam int TEST_W  = 6;

  typedef enum logic [ADDR_W-1:0] {
    A_FRAC_HI = 2'b00,
    A_FRAC_LO = 2'b01,
    A_DIVIDE  = 2'b10,
    A_CTRL    = 2'b11
  } reg_addr_e;

  localparam logic [PAY_W-1:0] RST_FRAC_HI = 14'd8192;
  localparam logic [PAY_W-1:0] RST_FRAC_LO = 14'd0;
  // ref=00, cp current=11, bleed=00, integer=177
  localparam logic [PAY_W-1:0] RST_DIVIDE  = {2'b00, 2'b11, 2'b00, 8'd177};
  // spare=00, test=0, control=15
  localparam logic [PAY_W-1:0] RST_CTRL    = {2'b00, 6'd0, 6'd15};

  function automatic logic [PAY_W-1:0] reset_word(input int idx);
    case (idx)
      0:       return RST_FRAC_HI;
      1:       return RST_FRAC_LO;
      2:       return RST_DIVIDE;
      default: return RST_CTRL;
    endcase
  endfunction
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[s] <= RST_VAL;
      else if (s == 0) stg[s] <= d_i;
      else stg[s] <= stg[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/cfg_shifter.sv
module cfg_shifter #(
  parameter int WORD_W = 16,
  parameter int ADDR_W = 2,
  localparam int PAY_W = WORD_W - ADDR_W,
  localparam int CNT_W = $clog2(WORD_W + 2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_i,
  input  logic              sdat_i,
  input  logic              sen_n_i,
  output logic              wr_stb_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [PAY_W-1:0]  wr_data_o,
  output logic [CNT_W-1:0]  bit_cnt_o
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(WORD_W + 1);

  logic              sclk_q, en_q;
  logic              sclk_rise, en_rise;
  logic [WORD_W-1:0] shreg;
  logic [CNT_W-1:0]  cnt;

  assign sclk_rise = sclk_i & ~sclk_q;
  assign en_rise   = sen_n_i & ~en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q    <= 1'b0;
      en_q      <= 1'b1;
      shreg     <= '0;
      cnt       <= '0;
      wr_stb_o  <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
    end else begin
      sclk_q   <= sclk_i;
      en_q     <= sen_n_i;
      wr_stb_o <= 1'b0;
      if (en_rise) begin
        if (cnt == CNT_FULL) begin
          wr_stb_o  <= 1'b1;
          wr_addr_o <= shreg[ADDR_W-1:0];
          wr_data_o <= shreg[WORD_W-1:ADDR_W];
        end
        cnt <= '0;
      end else if (sen_n_i) begin
        cnt <= '0;
      end else if (sclk_rise) begin
        shreg <= {shreg[WORD_W-2:0], sdat_i};
        if (cnt != CNT_OVER) cnt <= cnt + 1'b1;
      end
    end
  end

  assign bit_cnt_o = cnt;
endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile
  import cfg_port_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int PAY_W  = 14,
  localparam int NREG  = 1 << ADDR_W
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_stb_i,
  input  logic [ADDR_W-1:0]          wr_addr_i,
  input  logic [PAY_W-1:0]           wr_data_i,
  output logic [NREG-1:0][PAY_W-1:0] regs_o
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) regs_o[g] <= PAY_W'(reset_word(g));
      else if (wr_stb_i && wr_addr_i == ADDR_W'(g)) regs_o[g] <= wr_data_i;
    end
  end
endmodule

// File: rtl/cfg_serial_port.sv
module cfg_serial_port
  import cfg_port_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  ser_clk_i,
  input  logic                  ser_dat_i,
  input  logic                  ser_en_n_i,
  output logic [PAY_W-1:0]      frac_hi_o,
  output logic [PAY_W-1:0]      frac_lo_o,
  output logic [2*PAY_W-1:0]    frac_o,
  output logic [INT_W-1:0]      int_div_o,
  output logic [CODE_W-1:0]     ref_div_o,
  output logic [CODE_W-1:0]     cp_cur_o,
  output logic [CODE_W-1:0]     cp_bleed_o,
  output logic                  cp_double_o,
  output logic                  buf_en_o,
  output logic                  tx_en_o,
  output logic                  pwr_up_o,
  output logic                  int_mode_o,
  output logic [TEST_W-1:0]     test_o
);
  localparam int CNT_W = $clog2(WORD_W + 2);

  logic [2:0]                        sync_q;
  logic                              wr_stb;
  logic [ADDR_W-1:0]                 wr_addr;
  logic [PAY_W-1:0]                  wr_data;
  logic [CNT_W-1:0]                  bit_cnt;
  logic [NUM_REGS-1:0][PAY_W-1:0]    regs;
  logic [PAY_W-1:0]                  div_w, ctl_w;
  logic                              ctl_unused;

  cfg_sync #(.W(3), .STAGES(SYNC_STG), .RST_VAL(3'b100)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({ser_en_n_i, ser_dat_i, ser_clk_i}),
    .q_o (sync_q)
  );

  cfg_shifter #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .sclk_i    (sync_q[0]),
    .sdat_i    (sync_q[1]),
    .sen_n_i   (sync_q[2]),
    .wr_stb_o  (wr_stb),
    .wr_addr_o (wr_addr),
    .wr_data_o (wr_data),
    .bit_cnt_o (bit_cnt)
  );

  cfg_regfile #(.ADDR_W(ADDR_W), .PAY_W(PAY_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_stb_i  (wr_stb),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .regs_o    (regs)
  );

  assign div_w = regs[A_DIVIDE];
  assign ctl_w = regs[A_CTRL];

  assign frac_hi_o   = regs[A_FRAC_HI];
  assign frac_lo_o   = regs[A_FRAC_LO];
  assign frac_o      = {regs[A_FRAC_HI], regs[A_FRAC_LO]};
  assign int_div_o   = div_w[INT_W-1:0];
  assign cp_bleed_o  = div_w[INT_W +: CODE_W];
  assign cp_cur_o    = div_w[INT_W+CODE_W +: CODE_W];
  assign ref_div_o   = div_w[INT_W+2*CODE_W +: CODE_W];
  assign cp_double_o = ctl_w[0];
  assign buf_en_o    = ctl_w[2];
  assign tx_en_o     = ctl_w[3];
  assign pwr_up_o    = ctl_w[4];
  assign int_mode_o  = ctl_w[5];
  assign test_o      = ctl_w[CTRL_W +: TEST_W];
  assign ctl_unused  = ^{ctl_w[1], ctl_w[PAY_W-1:CTRL_W+TEST_W]};
endmodule

// File: rtl/cfg_serial_port_chk.sv
module cfg_serial_port_chk (
  input logic        clk,
  input logic        rst,
  input logic        wr_stb,
  input logic [1:0]  wr_addr,
  input logic [4:0]  bit_cnt,
  input logic [55:0] regs,
  input logic [13:0] frac_hi_o,
  input logic [13:0] frac_lo_o,
  input logic [7:0]  int_div_o,
  input logic [1:0]  cp_cur_o,
  input logic [5:0]  test_o,
  input logic        tx_en_o,
  input logic        pwr_up_o
);
  p_reset_vals_r1: assert property (@(posedge clk)
    rst |=> (frac_hi_o == 14'd8192 && frac_lo_o == 14'd0 && int_div_o == 8'd177 &&
             cp_cur_o == 2'b11 && test_o == 6'd0 && tx_en_o && !pwr_up_o));

  p_strobe_single_r2: assert property (@(posedge clk) disable iff (rst)
    wr_stb |=> !wr_stb);

  p_cnt_bounded_r6: assert property (@(posedge clk) disable iff (rst)
    bit_cnt <= 5'd17);

  p_hold_no_write_r10: assert property (@(posedge clk) disable iff (rst)
    !wr_stb |=> $stable(regs));

  p_others_kept_hi_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && wr_addr == 2'b00) |=> $stable(regs[55:14]));

  p_others_kept_ctl_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && wr_addr == 2'b11) |=> $stable(regs[41:0]));
endmodule

bind cfg_serial_port cfg_serial_port_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_stb    (wr_stb),
  .wr_addr   (wr_addr),
  .bit_cnt   (bit_cnt),
  .regs      (regs),
  .frac_hi_o (frac_hi_o),
  .frac_lo_o (frac_lo_o),
  .int_div_o (int_div_o),
  .cp_cur_o  (cp_cur_o),
  .test_o    (test_o),
  .tx_en_o   (tx_en_o),
  .pwr_up_o  (pwr_up_o)
);

// File: tb/cfg_serial_port_tb.sv
module cfg_serial_port_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0, sdat = 1'b0, sen_n = 1'b1;

  logic [13:0] frac_hi, frac_lo;
  logic [27:0] frac;
  logic [7:0]  int_div;
  logic [1:0]  ref_div, cp_cur, cp_bleed;
  logic        cp_double, buf_en, tx_en, pwr_up, int_mode;
  logic [5:0]  test_f;

  int total = 0;
  int bad   = 0;

  typedef struct {
    logic [13:0] e [4];
    string       tag;
  } item_t;

  item_t       sb_q [$];
  logic [13:0] mdl [4];

  always #4 clk = ~clk;

  cfg_serial_port u_dut (
    .clk (clk), .rst (rst),
    .ser_clk_i (sclk), .ser_dat_i (sdat), .ser_en_n_i (sen_n),
    .frac_hi_o (frac_hi), .frac_lo_o (frac_lo), .frac_o (frac),
    .int_div_o (int_div), .ref_div_o (ref_div), .cp_cur_o (cp_cur),
    .cp_bleed_o (cp_bleed), .cp_double_o (cp_double), .buf_en_o (buf_en),
    .tx_en_o (tx_en), .pwr_up_o (pwr_up), .int_mode_o (int_mode),
    .test_o (test_f)
  );

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    mdl[0] = 14'd8192;
    mdl[1] = 14'd0;
    mdl[2] = {2'b00, 2'b11, 2'b00, 8'd177};
    mdl[3] = 14'd15;
  endtask

  task automatic push(input string tag);
    item_t it;
    for (int k = 0; k < 4; k++) it.e[k] = mdl[k];
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  // sends the low n bits of w, MSB first; optionally holds the frame open
  task automatic send(input logic [31:0] w, input int n, input string tag,
                      input bit peek_open);
    sen_n = 1'b0;
    wait_clk(8);
    for (int i = n - 1; i >= 0; i--) begin
      sdat = w[i];
      wait_clk(4);
      sclk = 1'b1;
      wait_clk(8);
      sclk = 1'b0;
      wait_clk(4);
    end
    wait_clk(8);
    if (peek_open) begin
      push({tag, " open frame"});
      wait_clk(18);
    end
    sen_n = 1'b1;
    if (n == 16) mdl[w[1:0]] = w[15:2];
    push(tag);
    wait_clk(20);
  endtask

  task automatic write_reg(input logic [1:0] a, input logic [13:0] d,
                           input string tag);
    send({16'd0, d, a}, 16, tag, 1'b0);
  endtask

  // monitor: compares outputs against the queued expectations
  initial begin
    forever begin
      item_t it;
      wait (sb_q.size() > 0);
      wait_clk(12);
      it = sb_q.pop_front();
      check(frac_hi == it.e[0] && frac[27:14] == it.e[0],
            {it.tag, " frac upper"}, {18'd0, frac_hi}, {18'd0, it.e[0]});
      check(frac_lo == it.e[1] && frac[13:0] == it.e[1],
            {it.tag, " frac lower"}, {18'd0, frac_lo}, {18'd0, it.e[1]});
      check({ref_div, cp_cur, cp_bleed, int_div} == it.e[2],
            {it.tag, " divide fields"},
            {18'd0, ref_div, cp_cur, cp_bleed, int_div}, {18'd0, it.e[2]});
      check({test_f, int_mode, pwr_up, tx_en, buf_en, cp_double} ==
            {it.e[3][11:6], it.e[3][5:2], it.e[3][0]},
            {it.tag, " control fields"},
            {21'd0, test_f, int_mode, pwr_up, tx_en, buf_en, cp_double},
            {21'd0, it.e[3][11:6], it.e[3][5:2], it.e[3][0]});
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired act=%0d exp=0", 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    model_reset();
    wait_clk(5);
    rst = 1'b0;
    push("R1 reset values");
    wait_clk(20);

    write_reg(2'b00, 14'h2A5C, "R2 R3 R8 upper fraction");
    write_reg(2'b01, 14'h1337, "R3 R8 lower fraction");
    write_reg(2'b10, {2'b10, 2'b01, 2'b11, 8'd36}, "R4 R8 divide word");
    write_reg(2'b11, {2'b11, 6'b101101, 6'b110010}, "R5 R8 control word");
    write_reg(2'b10, {2'b01, 2'b10, 2'b00, 8'd251}, "R4 divide word alt");

    // 15 and 17 bit frames must be discarded
    send(32'h0000_7FFD, 15, "R6 short frame", 1'b0);
    send(32'h0001_5554, 17, "R6 long frame", 1'b0);

    // serial clock activity with enable high
    sdat = 1'b1;
    for (int i = 0; i < 5; i++) begin
      wait_clk(4); sclk = 1'b1; wait_clk(8); sclk = 1'b0;
    end
    push("R7 clocks while idle");
    wait_clk(20);
    write_reg(2'b01, 14'h0F0F, "R7 frame after idle clocks");

    // frame fully shifted, enable still low
    send({16'd0, 14'h3ABC, 2'b00}, 16, "R10 commit on enable", 1'b1);

    // power-down bit toggling keeps every register
    write_reg(2'b11, 14'h0010, "R9 power up set");
    write_reg(2'b11, 14'h0000, "R9 power down kept regs");

    wait_clk(4);
    rst = 1'b1;
    wait_clk(3);
    rst = 1'b0;
    model_reset();
    push("R1 R9 reset restores defaults");
    wait_clk(20);
    wait (sb_q.size() == 0);
    wait_clk(15);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule